// File: doc/BRIEF.md
# Register Allocation Table with Dual-Port Hazard Lookup

This block keeps one entry per general-purpose register. Each entry records whether the register is still waiting for a result from an instruction that is in flight, and which instruction tag will supply that result. An instruction can write two destination registers, for example the two halves of a 64-bit floating-point pair. For this reason each entry carries two pending flags, one per destination port, and one producer tag.

The table changes state on a clock edge in three cases:
- When decode advances an instruction into execution, the entries named by that instruction's destination addresses are claimed.
- When the retirement buffer broadcasts the tag of its oldest instruction, entries holding that tag are released.
- When the pipeline is flushed, every pending flag is dropped.

The table also has four source-operand lookup ports: A and B for the first half of an operand pair, and A and B for the second half. They are purely combinational. Each port returns a first-port hazard flag, a second-port hazard flag and the producer tag at its address. These outputs are registered by the reservation stations that consume them.

Top module: `reg_alloc_table`

## Requirements
- R1: After reset every pending flag is clear and every stored producer tag is zero, so all hazard outputs read 0 and all tag outputs read 0.
- R2: On a clock edge where `exec_adv` and `dst1_we` are both 1, the entry at index `dst1_addr` gets its first-port pending flag set.
- R3: On a clock edge where `exec_adv` and `dst2_we` are both 1, the entry at index `dst2_addr` gets its second-port pending flag set. This is independent of the first port.
- R4: With `exec_adv` low, the write enables and destination addresses have no effect on any entry.
- R5: An entry claimed by either destination port stores `dec_tag` as its producer tag. Every lookup port outputs the stored tag of the entry at its address.
- R6: When `retire_valid` is 1 and `retire_tag` equals an entry's stored tag, both pending flags of that entry clear on the next edge.
- R7: A retire whose tag differs from an entry's stored tag leaves that entry unchanged.
- R8: If the same entry is claimed and matched by a retire in the same cycle, the claim wins: the entry stays pending with the new tag.
- R9: `flush` clears all pending flags on the next edge. It takes priority over a claim in the same cycle, and it leaves the stored tags as they were.
- R10: For each lookup port, hazard1 = first-port flag at the source address AND the port's request bit, and hazard2 = second-port flag AND request. With the request low, both hazard outputs are 0.
- R11: The four lookup ports are independent. Port k uses address bits [5k+4:5k], request bit k, hazard bit k and tag bits [3k+2:3k].
- R12: A claim replaces both flags of the entry. The flag of a destination port that did not name the entry becomes 0 at that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all pending flags |
| exec_adv | input | 1 | Decode-to-execute advance strobe |
| dec_tag | input | 3 | Tag of the instruction being advanced |
| dst1_we | input | 1 | First destination port writes |
| dst1_addr | input | 5 | First destination register index |
| dst2_we | input | 1 | Second destination port writes |
| dst2_addr | input | 5 | Second destination register index |
| retire_valid | input | 1 | Retirement tag broadcast is valid |
| retire_tag | input | 3 | Tag of the oldest instruction retiring |
| src_req | input | 4 | Per-operand request bits |
| src_addr | input | 20 | Four packed 5-bit source indices |
| haz1 | output | 4 | Per-operand first-port hazard |
| haz2 | output | 4 | Per-operand second-port hazard |
| src_tag | output | 12 | Four packed 3-bit producer tags |

## Verification
The bench attacks the cycle where a claim and a matching retire hit the same entry. A design that gave the retire priority would report no hazard for a register that is still being produced. It pairs a flush with a claim, and lets a retire arrive for an old tag after the entry was re-claimed. A design that cleared on any retire, or let the claim survive the flush, would then show wrong flags. It also re-claims an entry through only one port and checks that the flag of the other port drops. Finally, it drops request bits on operands that address pending entries, which catches hazards that leak through without a request.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int RAT_NUM_REGS = 32;
  localparam int RAT_TAG_W    = 3;
  localparam int RAT_NUM_SRC  = 4;

  typedef struct packed {
    logic pend1;
    logic pend2;
  } rat_flags_t;
endpackage

// File: rtl/rat_entry.sv
module rat_entry
  import rat_pkg::*;
#(
  parameter int TAG_W  = RAT_TAG_W,
  parameter int ADDR_W = 5,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              exec_adv,
  input  logic [TAG_W-1:0]  dec_tag,
  input  logic              dst1_we,
  input  logic [ADDR_W-1:0] dst1_addr,
  input  logic              dst2_we,
  input  logic [ADDR_W-1:0] dst2_addr,
  input  logic              retire_valid,
  input  logic [TAG_W-1:0]  retire_tag,
  output rat_flags_t        flags,
  output logic [TAG_W-1:0]  tag
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

  logic       hit1, hit2, claim, release_hit;
  rat_flags_t flags_nxt;
  logic [TAG_W-1:0] tag_nxt;
  logic       tag_en;

  assign hit1        = exec_adv & dst1_we & (dst1_addr == MY_ADDR);
  assign hit2        = exec_adv & dst2_we & (dst2_addr == MY_ADDR);
  assign claim       = hit1 | hit2;
  assign release_hit = retire_valid & (retire_tag == tag);

  always_comb begin
    flags_nxt = flags;
    tag_en    = 1'b0;
    tag_nxt   = tag;
    if (flush) begin
      flags_nxt = '0;
    end else if (claim) begin
      flags_nxt.pend1 = hit1;
      flags_nxt.pend2 = hit2;
      tag_en          = 1'b1;
      tag_nxt         = dec_tag;
    end else if (release_hit) begin
      flags_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= flags_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag <= '0;
    end else if (tag_en) begin
      tag <= tag_nxt;
    end
  end

  // R2
  a_r2_claim_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && exec_adv && dst1_we && dst1_addr == MY_ADDR) |=> flags.pend1);
  // R3
  a_r3_claim_second: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && exec_adv && dst2_we && dst2_addr == MY_ADDR) |=> flags.pend2);
  // R5
  a_r5_tag_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && claim) |=> tag == $past(dec_tag));
  // R6
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !exec_adv && retire_valid && retire_tag == tag) |=> (flags == '0));
  // R4 and R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !exec_adv && !(retire_valid && retire_tag == tag))
      |=> ($stable(flags) && $stable(tag)));
  // R8
  a_r8_claim_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && claim && retire_valid && retire_tag == tag) |=> (flags != '0));
  // R9
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (flags == '0 && $stable(tag)));
  // R12
  a_r12_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && hit1 && !hit2) |=> !flags.pend2);
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup
  import rat_pkg::*;
#(
  parameter int NUM_REGS = RAT_NUM_REGS,
  parameter int TAG_W    = RAT_TAG_W,
  parameter int ADDR_W   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS-1:0]       pend1_vec,
  input  logic [NUM_REGS-1:0]       pend2_vec,
  input  logic [NUM_REGS*TAG_W-1:0] tag_vec,
  input  logic                      req,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      haz1,
  output logic                      haz2,
  output logic [TAG_W-1:0]          tag
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [SLOTS-1:0]       p1_pad, p2_pad;
  logic [SLOTS*TAG_W-1:0] t_pad;

  assign p1_pad = SLOTS'(pend1_vec);
  assign p2_pad = SLOTS'(pend2_vec);
  assign t_pad  = (SLOTS*TAG_W)'(tag_vec);

  always_comb begin
    haz1 = p1_pad[addr] & req;
    haz2 = p2_pad[addr] & req;
    tag  = t_pad[addr*TAG_W +: TAG_W];
  end

  // R10
  a_r10_req_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!haz1 && !haz2));
endmodule

// File: rtl/reg_alloc_table.sv
module reg_alloc_table
  import rat_pkg::*;
#(
  parameter int NUM_REGS = RAT_NUM_REGS,
  parameter int TAG_W    = RAT_TAG_W,
  parameter int NUM_SRC  = RAT_NUM_SRC,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       exec_adv,
  input  logic [TAG_W-1:0]           dec_tag,
  input  logic                       dst1_we,
  input  logic [ADDR_W-1:0]          dst1_addr,
  input  logic                       dst2_we,
  input  logic [ADDR_W-1:0]          dst2_addr,
  input  logic                       retire_valid,
  input  logic [TAG_W-1:0]           retire_tag,
  input  logic [NUM_SRC-1:0]         src_req,
  input  logic [NUM_SRC*ADDR_W-1:0]  src_addr,
  output logic [NUM_SRC-1:0]         haz1,
  output logic [NUM_SRC-1:0]         haz2,
  output logic [NUM_SRC*TAG_W-1:0]   src_tag
);
  logic [NUM_REGS-1:0]       pend1_vec, pend2_vec;
  logic [NUM_REGS*TAG_W-1:0] tag_vec;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
    rat_flags_t       fl;
    logic [TAG_W-1:0] tg;
    rat_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .IDX(r)) u_entry (
      .clk(clk), .rst_n(rst_n), .flush(flush), .exec_adv(exec_adv),
      .dec_tag(dec_tag), .dst1_we(dst1_we), .dst1_addr(dst1_addr),
      .dst2_we(dst2_we), .dst2_addr(dst2_addr),
      .retire_valid(retire_valid), .retire_tag(retire_tag),
      .flags(fl), .tag(tg));
    assign pend1_vec[r]                = fl.pend1;
    assign pend2_vec[r]                = fl.pend2;
    assign tag_vec[r*TAG_W +: TAG_W]   = tg;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rat_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_lookup (
      .clk(clk), .rst_n(rst_n),
      .pend1_vec(pend1_vec), .pend2_vec(pend2_vec), .tag_vec(tag_vec),
      .req(src_req[s]), .addr(src_addr[s*ADDR_W +: ADDR_W]),
      .haz1(haz1[s]), .haz2(haz2[s]), .tag(src_tag[s*TAG_W +: TAG_W]));
  end

  // R9: the cycle after a flush, no operand may see any hazard
  a_r9_no_hazard_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (haz1 == '0 && haz2 == '0));
endmodule

// File: tb/reg_alloc_table_bench.sv
`timescale 1ns/1ps
module reg_alloc_table_bench;
  localparam int NR = 32, TW = 3, NS = 4, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush, exec_adv, dst1_we, dst2_we, retire_valid;
  logic [TW-1:0] dec_tag, retire_tag;
  logic [AW-1:0] dst1_addr, dst2_addr;
  logic [NS-1:0] src_req, haz1, haz2;
  logic [NS*AW-1:0] src_addr;
  logic [NS*TW-1:0] src_tag;

  int total = 0, bad = 0, cycles = 0;
  bit m1[NR], m2[NR];
  int mt[NR];

  always #2.5 clk = ~clk;

  reg_alloc_table u_reg_alloc_table (
    .clk(clk), .rst_n(rst_n), .flush(flush), .exec_adv(exec_adv),
    .dec_tag(dec_tag), .dst1_we(dst1_we), .dst1_addr(dst1_addr),
    .dst2_we(dst2_we), .dst2_addr(dst2_addr), .retire_valid(retire_valid),
    .retire_tag(retire_tag), .src_req(src_req), .src_addr(src_addr),
    .haz1(haz1), .haz2(haz2), .src_tag(src_tag));

  task automatic idle();
    flush = 0; exec_adv = 0; dst1_we = 0; dst2_we = 0; retire_valid = 0;
    dec_tag = 0; retire_tag = 0; dst1_addr = 0; dst2_addr = 0;
  endtask

  task automatic look(input int a0, input int a1, input int a2, input int a3,
                      input logic [3:0] rq);
    src_addr = {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
    src_req  = rq;
  endtask

  // compare outputs against model, then advance model and clock
  task automatic step(input string rq);
    #1;
    for (int k = 0; k < NS; k++) begin
      int a = int'(src_addr[k*AW +: AW]);
      logic e1 = src_req[k] & m1[a];
      logic e2 = src_req[k] & m2[a];
      logic [TW-1:0] et = TW'(mt[a]);
      total++;
      if (haz1[k] !== e1 || haz2[k] !== e2 || src_tag[k*TW +: TW] !== et) begin
        bad++;
        $display("FAIL %s op%0d addr=%0d actual h1=%b h2=%b tag=%0d expected h1=%b h2=%b tag=%0d",
                 rq, k, a, haz1[k], haz2[k], src_tag[k*TW +: TW], e1, e2, et);
      end
    end
    for (int r = 0; r < NR; r++) begin
      bit h1 = exec_adv && dst1_we && int'(dst1_addr) == r;
      bit h2 = exec_adv && dst2_we && int'(dst2_addr) == r;
      if (flush) begin m1[r] = 0; m2[r] = 0; end
      else if (h1 || h2) begin m1[r] = h1; m2[r] = h2; mt[r] = int'(dec_tag); end
      else if (retire_valid && int'(retire_tag) == mt[r]) begin m1[r] = 0; m2[r] = 0; end
    end
    @(posedge clk); @(negedge clk);
    cycles++;
  endtask

  initial begin : watchdog
    #900000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin m1[r] = 0; m2[r] = 0; mt[r] = 0; end
    idle(); look(0, 5, 17, 31, 4'hF);
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");
    // R2: first port claim reg 5 tag 3
    exec_adv = 1; dst1_we = 1; dst1_addr = 5; dec_tag = 3;
    step("R2"); idle(); look(5, 5, 6, 0, 4'hF); step("R2");
    // R3: second port reg 6 with first port reg 7, tag 4
    exec_adv = 1; dst1_we = 1; dst1_addr = 7; dst2_we = 1; dst2_addr = 6; dec_tag = 4;
    step("R3"); idle(); look(6, 7, 5, 6, 4'hF); step("R3");
    // R4: write enables without advance
    dst1_we = 1; dst1_addr = 9; dst2_we = 1; dst2_addr = 10; dec_tag = 6;
    step("R4"); idle(); look(9, 10, 9, 10, 4'hF); step("R4");
    // R5/R11: tags visible on mixed ports
    look(7, 5, 6, 9, 4'hF); step("R5"); look(31, 6, 7, 5, 4'hF); step("R11");
    // R7: retire mismatch
    retire_valid = 1; retire_tag = 6; step("R7"); idle(); look(5, 6, 7, 0, 4'hF); step("R7");
    // R6: retire tag 3 releases reg 5
    retire_valid = 1; retire_tag = 3; step("R6"); idle(); look(5, 6, 7, 5, 4'hF); step("R6");
    // R8: claim reg 7 tag 5 while tag 4 retires; reg 6 releases, reg 7 stays
    exec_adv = 1; dst1_we = 1; dst1_addr = 7; dec_tag = 5; retire_valid = 1; retire_tag = 4;
    step("R8"); idle(); look(7, 6, 7, 6, 4'hF); step("R8");
    // R12: reg 12 both ports, then first port only
    exec_adv = 1; dst1_we = 1; dst1_addr = 12; dst2_we = 1; dst2_addr = 12; dec_tag = 1;
    step("R12"); idle(); look(12, 12, 0, 0, 4'h3); step("R12");
    exec_adv = 1; dst1_we = 1; dst1_addr = 12; dec_tag = 2;
    step("R12"); idle(); look(12, 12, 12, 12, 4'hF); step("R12");
    // R10: requests low on pending regs
    look(12, 7, 12, 7, 4'h0); step("R10"); look(12, 7, 12, 7, 4'h5); step("R10");
    // R9: flush with a claim
    flush = 1; exec_adv = 1; dst1_we = 1; dst1_addr = 20; dec_tag = 7;
    step("R9"); idle(); look(12, 7, 20, 5, 4'hF); step("R9");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      flush        = ($urandom_range(0, 63) == 0);
      exec_adv     = $urandom_range(0, 1);
      dst1_we      = $urandom_range(0, 1);
      dst2_we      = ($urandom_range(0, 3) == 0);
      dst1_addr    = AW'($urandom_range(0, 15));
      dst2_addr    = AW'($urandom_range(0, 15));
      dec_tag      = TW'($urandom_range(1, 7));
      retire_valid = $urandom_range(0, 1);
      retire_tag   = TW'($urandom_range(1, 7));
      look($urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 15), 4'($urandom_range(0, 15)));
      step("R11");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule